// File: doc/BRIEF.md
# Banked Translation Table Base Register

This block is the system control register that holds where the first-level translation table lives in memory, plus the cache and shareability attributes that a table walker uses when it fetches descriptors. It keeps one copy for the secure world and one for the non-secure world. The current security state of each access picks the copy that is read or written, and the same state picks the copy whose decoded fields drive the outputs.

The register has two layouts. When `long_fmt_i` is 0 it is a 32-bit register that carries a base address and the walk attributes. When `long_fmt_i` is 1 it is a 64-bit register that carries a 48-bit base address and an 8-bit address-space identifier. Software can write base bits below the required table alignment, and it reads them back unchanged. The effective base output treats those bits as zero, and in the long layout a misalignment flag shows that some of them are set. The alignment point comes from the size fields `n_i` and `t0sz_i`.

Access is by read and write strobes that carry a privilege level and a security state. Requests from the user level are refused. A dedicated input locks the secure copy against writes.

Top module: `xlat_base_bank`

## Requirements
- R1: Any read or write with `priv_i == 0` raises `fault_o` for exactly one cycle, one clock after the request. That access returns zero `rdata_o` and changes neither copy. When `priv_i` is 1, 2 or 3, the access is permitted and `fault_o` stays low.
- R2: A permitted read returns the selected copy on `rdata_o` one cycle after the strobe, and the value is the one held before any write in the same cycle. In the short layout bits [63:32] and bit 2 read as zero. When no permitted read is made, `rdata_o` is zero.
- R3: `secure_i` selects the copy: 1 is the secure copy, 0 the non-secure copy. A write changes only that copy, and every decoded output reflects only that copy.
- R4: While `sec_wr_lock_i` is high, a write with `secure_i = 1` is ignored without a fault. Writes to the non-secure copy are still accepted.
- R5: Short layout fields:
  - base in [31:7]
  - inner cacheability code = {bit 0, bit 6}
  - outer cacheability code in [4:3]
  - shareable in bit 1
  - inner-shareable select in bit 5
  - bit 2 is ignored on write
- R6: In the short layout the alignment point is x = 14 − `n_i`. `base_o` equals bits [31:x] of the stored value with every lower bit zero, and bits [47:32] are zero. Bits [x−1:7] still read back as written.
- R7: Long layout fields: the address-space identifier is in [55:48] and drives `asid_o`. Bits [63:56] are ignored on write and read as zero. In this layout the attribute outputs and the inner-shareable output are zero; in the short layout `asid_o` is zero.
- R8: In the long layout x is 5 − `t0sz_i` when `t0sz_i` is 0 or 1, and 14 − `t0sz_i` otherwise. `base_o` equals stored bits [47:x] with bits [x−1:0] zero. `misalign_o` is high exactly when stored bits [x−1:3] are not all zero; in the short layout it is always low.
- R9: In the long layout, a write with `wide_i = 0` updates only bits [31:0]. A write with `wide_i = 1` updates all 64 bits in the same cycle. In the short layout every write updates only bits [31:0].
- R10: After reset both copies are all zeros.
- R11: `inner_shr_o` is high only when the shareable bit is set. When the shareable bit is 0, the inner-shareable select bit has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 2 | Privilege level of the access (0 = user) |
| secure_i | input | 1 | Security state: 1 secure, 0 non-secure |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wide_i | input | 1 | Write carries 64 bits |
| wdata_i | input | 64 | Write data |
| sec_wr_lock_i | input | 1 | Blocks writes to the secure copy |
| long_fmt_i | input | 1 | Selects the 64-bit layout |
| n_i | input | 3 | Short-layout size field |
| t0sz_i | input | 3 | Long-layout size field |
| rdata_o | output | 64 | Registered read data |
| fault_o | output | 1 | One-cycle access fault |
| base_o | output | 48 | Effective aligned table base |
| misalign_o | output | 1 | Long-layout misalignment flag |
| inner_attr_o | output | 2 | Inner cacheability code for walks |
| outer_attr_o | output | 2 | Outer cacheability code for walks |
| shareable_o | output | 1 | Walks are shareable |
| inner_shr_o | output | 1 | Shareable walks are inner rather than outer shareable |
| asid_o | output | 8 | Address-space identifier (long layout) |

## Verification
The bench sweeps every value of `n_i` and `t0sz_i` over bases that have the low bits set. A wrong alignment formula, especially the jump at `t0sz_i` = 2, shows up as a wrong `base_o` or a missing `misalign_o`. It crosses the two copies with the secure lock and with user-level requests, so a write that leaks into the wrong copy or lands despite the lock shows up on a later read. It also checks three cases where stale bits could surface:
- a narrow write in the long layout, where upper bits could be lost;
- a read that coincides with a write, which could return the new value instead of the old;
- a layout switch, which could expose stored bit 2 or the upper word.

// File: rtl/xlat_base_pkg.sv
package xlat_base_pkg;
  parameter int unsigned REG_W      = 64;
  parameter int unsigned SHORT_W    = 32;
  parameter int unsigned BASE_W     = 48;
  parameter int unsigned ASID_W     = 8;
  parameter int unsigned ASID_LSB   = 48;
  parameter int unsigned SHORT_LSB  = 7;
  parameter int unsigned LONG_CHK   = 3;
  parameter int unsigned ALIGN_CAP  = 14;
  parameter int unsigned SMALL_CAP  = 5;
  parameter int unsigned SIZE_W     = 3;
  parameter int unsigned PRIV_W     = 2;
  parameter int unsigned N_BANKS    = 2;

  typedef struct packed {
    logic [1:0] inner;
    logic [1:0] outer;
    logic       shareable;
    logic       inner_shr;
  } walk_attr_t;
endpackage

// File: rtl/xb_access_gate.sv
module xb_access_gate
  import xlat_base_pkg::*;
(
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              secure_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              lock_i,
  output logic              rd_ok_o,
  output logic              fault_o,
  output logic [N_BANKS-1:0] we_o
);
  logic allowed;
  assign allowed = (priv_i != '0);
  assign rd_ok_o = rd_i && allowed;
  assign fault_o = (rd_i || wr_i) && !allowed;

  always_comb begin
    we_o = '0;
    if (wr_i && allowed) begin
      if (secure_i) we_o[1] = !lock_i;
      else          we_o[0] = 1'b1;
    end
  end
endmodule

// File: rtl/xb_bank_reg.sv
module xb_bank_reg
  import xlat_base_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             wide_i,
  input  logic             long_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  localparam int unsigned RES_LSB = ASID_LSB + ASID_W;
  localparam logic [REG_W-1:0] KEEP = REG_W'((65'(1) << RES_LSB) - 65'(1));
  localparam int unsigned RES_BIT = 2;

  logic [REG_W-1:0] nxt;

  always_comb begin
    nxt = q_o;
    if (long_i && wide_i) begin
      nxt = wdata_i & KEEP;
    end else begin
      nxt[SHORT_W-1:0] = wdata_i[SHORT_W-1:0];
      if (!long_i) nxt[RES_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= nxt;
  end

  // R3: a copy without write enable holds
  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
  // R7: reserved top byte never stored
  a_r7_res_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o[REG_W-1:RES_LSB] == '0);
endmodule

// File: rtl/xb_base_align.sv
module xb_base_align
  import xlat_base_pkg::*;
(
  input  logic [REG_W-1:0]  raw_i,
  input  logic              long_i,
  input  logic [SIZE_W-1:0] n_i,
  input  logic [SIZE_W-1:0] t0sz_i,
  output logic [BASE_W-1:0] base_o,
  output logic              misalign_o,
  output walk_attr_t        attr_o,
  output logic [ASID_W-1:0] asid_o
);
  localparam logic [BASE_W-1:0] SHORT_LOW = BASE_W'((1 << SHORT_LSB) - 1);
  localparam logic [BASE_W-1:0] LONG_LOW  = BASE_W'((1 << LONG_CHK) - 1);

  logic [3:0]        x;
  logic [BASE_W-1:0] mask, short_full, long_full;

  always_comb begin
    if (!long_i)                  x = 4'(ALIGN_CAP) - {1'b0, n_i};
    else if (t0sz_i < SIZE_W'(2)) x = 4'(SMALL_CAP) - {1'b0, t0sz_i};
    else                          x = 4'(ALIGN_CAP) - {1'b0, t0sz_i};
  end

  assign mask       = {BASE_W{1'b1}} << x;
  assign short_full = {{(BASE_W-SHORT_W){1'b0}}, raw_i[SHORT_W-1:SHORT_LSB], {SHORT_LSB{1'b0}}};
  assign long_full  = raw_i[BASE_W-1:0];

  always_comb begin
    if (long_i) begin
      base_o     = long_full & mask;
      misalign_o = |(long_full & ~mask & ~LONG_LOW);
      attr_o     = '0;
      asid_o     = raw_i[ASID_LSB +: ASID_W];
    end else begin
      base_o           = short_full & mask;
      misalign_o       = 1'b0;
      attr_o.inner     = {raw_i[0], raw_i[6]};
      attr_o.outer     = raw_i[4:3];
      attr_o.shareable = raw_i[1];
      attr_o.inner_shr = raw_i[1] & raw_i[5];
      asid_o           = '0;
    end
  end
endmodule

// File: rtl/xlat_base_bank.sv
module xlat_base_bank
  import xlat_base_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              secure_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              sec_wr_lock_i,
  input  logic              long_fmt_i,
  input  logic [SIZE_W-1:0] n_i,
  input  logic [SIZE_W-1:0] t0sz_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              fault_o,
  output logic [BASE_W-1:0] base_o,
  output logic              misalign_o,
  output logic [1:0]        inner_attr_o,
  output logic [1:0]        outer_attr_o,
  output logic              shareable_o,
  output logic              inner_shr_o,
  output logic [ASID_W-1:0] asid_o
);
  logic [N_BANKS-1:0] we;
  logic               rd_ok, fault_now;
  logic [REG_W-1:0]   bank_q [N_BANKS];
  logic [REG_W-1:0]   sel_q, rd_val;
  walk_attr_t         attr;

  xb_access_gate u_gate (
    .priv_i  (priv_i),
    .secure_i(secure_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .lock_i  (sec_wr_lock_i),
    .rd_ok_o (rd_ok),
    .fault_o (fault_now),
    .we_o    (we)
  );

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    xb_bank_reg u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we[g]),
      .wide_i (wide_i),
      .long_i (long_fmt_i),
      .wdata_i(wdata_i),
      .q_o    (bank_q[g])
    );
  end

  assign sel_q = secure_i ? bank_q[1] : bank_q[0];

  // short view hides upper word and reserved bit 2
  assign rd_val = long_fmt_i ? sel_q
                : {{(REG_W-SHORT_W){1'b0}}, sel_q[SHORT_W-1:3], 1'b0, sel_q[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      fault_o <= 1'b0;
    end else begin
      rdata_o <= rd_ok ? rd_val : '0;
      fault_o <= fault_now;
    end
  end

  xb_base_align u_align (
    .raw_i     (sel_q),
    .long_i    (long_fmt_i),
    .n_i       (n_i),
    .t0sz_i    (t0sz_i),
    .base_o    (base_o),
    .misalign_o(misalign_o),
    .attr_o    (attr),
    .asid_o    (asid_o)
  );

  assign inner_attr_o = attr.inner;
  assign outer_attr_o = attr.outer;
  assign shareable_o  = attr.shareable;
  assign inner_shr_o  = attr.inner_shr;

  a_r1_fault_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> rdata_o == '0);
  a_r1_user_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && priv_i == '0) |=> ($stable(bank_q[0]) && $stable(bank_q[1])));
  a_r4_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && secure_i && sec_wr_lock_i) |=> $stable(bank_q[1]));
  a_r2_short_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !long_fmt_i) |=> (rdata_o[REG_W-1:SHORT_W] == '0 && !rdata_o[2]));
  a_r8_long_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_fmt_i |-> base_o[LONG_CHK:0] == '0);
  a_r6_short_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !long_fmt_i |-> (base_o[SHORT_LSB-1:0] == '0 && base_o[BASE_W-1:SHORT_W] == '0 && !misalign_o));
  a_r11_nos_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shareable_o |-> !inner_shr_o);
endmodule

// File: tb/sim_xlat_base_bank.sv
`timescale 1ns/1ps
module sim_xlat_base_bank;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  priv = 2'd1;
  logic        sec = 0, rd = 0, wr = 0, wide = 0, lock = 0, lng = 0;
  logic [63:0] wd = '0;
  logic [2:0]  n = '0, t0 = '0;

  logic [63:0] rdata;
  logic        fault, misal, shr, ishr;
  logic [47:0] base;
  logic [1:0]  iat, oat;
  logic [7:0]  asid;

  xlat_base_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .secure_i(sec), .rd_i(rd), .wr_i(wr),
    .wide_i(wide), .wdata_i(wd), .sec_wr_lock_i(lock), .long_fmt_i(lng), .n_i(n),
    .t0sz_i(t0), .rdata_o(rdata), .fault_o(fault), .base_o(base), .misalign_o(misal),
    .inner_attr_o(iat), .outer_attr_o(oat), .shareable_o(shr), .inner_shr_o(ishr),
    .asid_o(asid));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] m [2];
  logic [63:0] exp_rd;
  logic        exp_fault;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    logic [63:0] r;
    logic [47:0] b;
    int x, lo;
    logic ms;
    r = m[sec];
    if (lng) begin
      x = (t0 < 2) ? 5 - int'(t0) : 14 - int'(t0);
      b = r[47:0];
      lo = 3;
    end else begin
      x = 14 - int'(n);
      b = {16'h0, r[31:0]};
      lo = 7;
    end
    ms = 1'b0;
    for (int i = lo; i < x; i++) if (b[i]) ms = 1'b1;
    for (int i = 0; i < x; i++) b[i] = 1'b0;
    if (!lng) ms = 1'b0;
    chk(tag, "rdata", rdata, exp_rd);
    chk(tag, "fault", 64'(fault), 64'(exp_fault));
    chk(tag, "base", 64'(base), 64'(b));
    chk(tag, "misalign", 64'(misal), 64'(ms));
    chk(tag, "inner", 64'(iat), lng ? 64'd0 : 64'({r[0], r[6]}));
    chk(tag, "outer", 64'(oat), lng ? 64'd0 : 64'(r[4:3]));
    chk(tag, "share", 64'(shr), lng ? 64'd0 : 64'(r[1]));
    chk(tag, "inner_shr", 64'(ishr), lng ? 64'd0 : 64'(r[1] && r[5]));
    chk(tag, "asid", 64'(asid), lng ? 64'(r[55:48]) : 64'd0);
  endtask

  task automatic step(string tag);
    bit ok;
    ok = (priv != 0);
    exp_fault = (rd || wr) && !ok;
    exp_rd = '0;
    if (rd && ok) exp_rd = lng ? m[sec] : {32'h0, m[sec][31:0] & ~32'h4};
    if (wr && ok && !(sec && lock)) begin
      if (lng && wide) m[sec] = {8'h0, wd[55:0]};
      else begin
        m[sec][31:0] = wd[31:0];
        if (!lng) m[sec][2] = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
    rd = 0; wr = 0;
  endtask

  task automatic do_wr(string tag, logic s, logic [63:0] v, logic w);
    sec = s; wd = v; wide = w; wr = 1; step(tag);
  endtask
  task automatic do_rd(string tag, logic s);
    sec = s; rd = 1; step(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m[0] = '0; m[1] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: both copies zero after reset
    do_rd("R10", 0);
    do_rd("R10", 1);
    // R1: user level refused, other levels accepted
    priv = 0;
    do_wr("R1", 0, 64'hFFFF_FFFF, 0);
    do_rd("R1", 0);
    rd = 1; wr = 1; sec = 1; wd = 64'h1234_5678; step("R1");
    for (int p = 1; p < 4; p++) begin
      priv = 2'(p);
      do_wr("R1", 0, 64'(32'h0000_4000 * p), 0);
      do_rd("R1", 0);
    end
    priv = 1;
    // R5 R11: short layout attributes, NOS ignored without S
    do_wr("R5", 0, 64'h0000_C07F, 0);
    do_rd("R5", 0);
    do_wr("R11", 0, 64'h0000_C021, 0);
    do_rd("R11", 0);
    do_wr("R11", 0, 64'h0000_C023, 0);
    // R6: alignment sweep, low bits read back
    do_wr("R6", 0, 64'hFFFF_FF80, 0);
    for (int k = 0; k < 8; k++) begin
      n = 3'(k);
      do_rd("R6", 0);
    end
    n = 0;
    // R3: secure write leaves non-secure copy
    do_wr("R3", 1, 64'hA5A5_0002, 0);
    do_rd("R3", 0);
    do_rd("R3", 1);
    // R4: lock blocks secure only
    lock = 1;
    do_wr("R4", 1, 64'h1111_1111, 0);
    do_rd("R4", 1);
    do_wr("R4", 0, 64'h2222_2220, 0);
    do_rd("R4", 0);
    lock = 0;
    // R2: read with write in same cycle returns old value
    sec = 0; rd = 1; wr = 1; wd = 64'h3333_3330; step("R2");
    do_rd("R2", 0);
    // R7 R8: long layout, wide write with reserved byte set
    lng = 1;
    do_wr("R7", 0, 64'hFF5A_0000_1234_5FF8, 1);
    do_rd("R7", 0);
    for (int k = 0; k < 8; k++) begin
      t0 = 3'(k);
      do_rd("R8", 0);
    end
    do_wr("R8", 0, 64'h0000_0000_0000_0007, 0);
    t0 = 0; do_rd("R8", 0);
    t0 = 2; do_rd("R8", 0);
    // R9: narrow write in long layout keeps upper word
    do_wr("R9", 0, 64'hDEAD_BEEF_CAFE_F00C, 0);
    do_rd("R9", 0);
    do_wr("R9", 0, 64'h0077_0001_0000_0004, 1);
    do_rd("R9", 0);
    // R2: switch back to short hides upper word and bit 2
    lng = 0;
    do_rd("R2", 0);
    // mixed sweep
    for (int i = 0; i < 400; i++) begin
      priv = 2'($urandom_range(0, 3));
      lng  = 1'($urandom);
      lock = 1'($urandom);
      n    = 3'($urandom);
      t0   = 3'($urandom);
      wd   = {$urandom, $urandom};
      wide = 1'($urandom);
      sec  = 1'($urandom);
      rd   = 1'($urandom);
      wr   = 1'($urandom);
      step("R3");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule